// File: doc/BRIEF.md
# Transition-Triggered Wake and Latch Controller

This block sequences power for a memory-and-logic peripheral that hangs off a microcontroller bus. It watches a group of monitored address and logic lines. When any one of them changes, it opens an "active" window: the power-enable strobe goes high, a settle counter runs long enough for the downstream logic to produce stable data, and a single-cycle latch strobe then captures that data into output holding registers. After that the controller returns to standby by itself. The held outputs stay on the pins for as long as the bus stays quiet.

The usual trigger is the new address that appears after the address-latch-enable pulse at the start of a bus cycle. A select input gates the whole mechanism. While select is low, the controller sits in standby whatever the monitored lines do. A wrapping counter of completed wake cycles lets a bench relate activity to how often the inputs toggle. The monitored lines pass through a synchronizer, so a change is acted on a fixed number of cycles after it is first sampled.

Top module: `wake_latch_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pwr_en` and `latch_en` are 0, `data_out` is 0 and `wake_cnt` is 0. Monitored inputs that are held constant through reset cause no wake afterwards.
- R2: With `sel` high, a change on any bit of `mon_in` first sampled at clock edge k raises `pwr_en` after edge k+2.
- R3: An active phase is `SETTLE_CYC` cycles of settling followed by exactly one cycle with `latch_en` high. `pwr_en` is high throughout and falls on the next edge, unless a new change restarts the phase.
- R4: `data_out` takes the `data_raw` value sampled at the clock edge that ends the `latch_en` cycle. At every other edge `data_out` keeps its value.
- R5: A change detected during settling restarts the settle count from zero, so the capture reflects the most recent inputs.
- R6: If `mon_in` does not change, the controller stays in standby with `pwr_en` low, and `data_out` and `wake_cnt` do not move.
- R7: `sel` low at a clock edge puts the controller in standby after that edge. A change whose detection edge (k+2) finds `sel` low is discarded. A capture already strobed on `latch_en` still completes.
- R8: `wake_cnt` increases by one at each edge that ends a `latch_en` cycle, and wraps modulo 2^`CNT_W`.
- R9: Counted from the edge that starts or restarts settling, the edge that ends the latch cycle comes within `ACCESS_BUDGET` cycles.
- R10: A change detected on the edge that ends a latch cycle has two effects on that edge: the capture still happens, and a fresh settle phase starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Select; low forces standby |
| mon_in | input | IN_W | Monitored address and logic lines |
| data_raw | input | DATA_W | Unlatched data from the downstream logic |
| pwr_en | output | 1 | Active-domain enable |
| latch_en | output | 1 | One-cycle capture strobe |
| data_out | output | DATA_W | Held output data |
| wake_cnt | output | CNT_W | Completed wake cycles, wrapping |

## Verification
Two functions can coincide on one edge: the capture that closes an active phase, and the detection of a fresh input change that must open the next phase. The bench times a second toggle five cycles after the first, so that its detection lands exactly on the edge that ends the latch cycle. It then expects the capture, the count step and continued power-enable all at once. A second collision drops select in the middle of settling, where the forced standby has to override the running counter. Every cycle is compared against a behavioural model that uses delayed input samples.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    ST_STBY   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CAPT   = 2'd2
  } wl_state_t;
endpackage

// File: rtl/wl_sync.sv
// Multi-stage synchronizer for the monitored lines; reset preloads every
// stage with the live input so a steady bus produces no change after reset.
module wl_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= din;
    else     stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= din;
      else     stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/wl_edge_det.sv
// Registered previous copy; any differing bit flags a transition.
module wl_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] cur,
  output logic         chg
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= seed;
    else     prev <= cur;
  end

  assign chg = |(cur ^ prev);
endmodule

// File: rtl/wl_seq.sv
// Standby / settle / capture sequencer with wake tally and budget checker.
module wl_seq
  import wl_pkg::*;
#(
  parameter int SETTLE_CYC    = 4,
  parameter int ACCESS_BUDGET = 6,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             chg,
  output logic             pwr_en,
  output logic             cap,
  output logic [CNT_W-1:0] wake_cnt
);
  localparam int CW    = $clog2(SETTLE_CYC + 1);
  localparam int RUN_W = $clog2(SETTLE_CYC + ACCESS_BUDGET + 2) + 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  wl_state_t     st, nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt     = st;
    cnt_nxt = cnt;
    if (!sel) begin
      nxt     = ST_STBY;
      cnt_nxt = '0;
    end else begin
      case (st)
        ST_STBY: begin
          if (chg) begin
            nxt     = ST_SETTLE;
            cnt_nxt = '0;
          end
        end
        ST_SETTLE: begin
          if (chg)              cnt_nxt = '0;
          else if (cnt == LAST) nxt     = ST_CAPT;
          else                  cnt_nxt = cnt + 1'b1;
        end
        ST_CAPT: begin
          cnt_nxt = '0;
          nxt     = chg ? ST_SETTLE : ST_STBY;
        end
        default: nxt = ST_STBY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_STBY;
      cnt      <= '0;
      wake_cnt <= '0;
    end else begin
      st  <= nxt;
      cnt <= cnt_nxt;
      if (st == ST_CAPT) wake_cnt <= wake_cnt + 1'b1;
    end
  end

  assign pwr_en = (st != ST_STBY);
  assign cap    = (st == ST_CAPT);

  // budget window: cycles since the last (re)start of settling
  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (nxt == ST_SETTLE && (st != ST_SETTLE || chg)) run <= RUN_W'(1);
    else if (nxt != ST_STBY) run <= run + 1'b1;
    else run <= '0;
  end

  p_budget_r9: assert property (@(posedge clk) disable iff (rst)
    run <= RUN_W'(ACCESS_BUDGET));
  p_wake_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STBY && sel && chg) |=> (st == ST_SETTLE && cnt == '0));
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    cap |=> !cap);
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE && sel && chg) |=> (st == ST_SETTLE && cnt == '0));
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STBY && !chg) |=> (st == ST_STBY));
  p_sel_standby_r7: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !pwr_en);
  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    cap |=> (wake_cnt == $past(wake_cnt) + 1'b1));
  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(wake_cnt));
  p_collide_r10: assert property (@(posedge clk) disable iff (rst)
    (cap && sel && chg) |=> (st == ST_SETTLE));
endmodule

// File: rtl/wl_hold.sv
// Output holding register loaded on the capture strobe.
module wl_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q));
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    cap |=> (q == $past(d)));
endmodule

// File: rtl/wake_latch_ctrl.sv
module wake_latch_ctrl #(
  parameter int IN_W          = 8,
  parameter int DATA_W        = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYC    = 4,
  parameter int ACCESS_BUDGET = 6,
  parameter int CNT_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [IN_W-1:0]   mon_in,
  input  logic [DATA_W-1:0] data_raw,
  output logic              pwr_en,
  output logic              latch_en,
  output logic [DATA_W-1:0] data_out,
  output logic [CNT_W-1:0]  wake_cnt
);
  logic [IN_W-1:0] mon_s;
  logic            chg;

  wl_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(mon_in), .dout(mon_s)
  );

  wl_edge_det #(.W(IN_W)) u_edge (
    .clk(clk), .rst(rst), .seed(mon_in), .cur(mon_s), .chg(chg)
  );

  wl_seq #(
    .SETTLE_CYC(SETTLE_CYC), .ACCESS_BUDGET(ACCESS_BUDGET), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .sel(sel), .chg(chg),
    .pwr_en(pwr_en), .cap(latch_en), .wake_cnt(wake_cnt)
  );

  wl_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .cap(latch_en), .d(data_raw), .q(data_out)
  );
endmodule

// File: tb/wake_latch_ctrl_bench.sv
module wake_latch_ctrl_bench;
  localparam int S = 4;
  localparam int B = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b1;
  logic [7:0]  mon_in = 8'h5A;
  logic [15:0] data_raw = 16'h0;
  logic        pwr_en, latch_en;
  logic [15:0] data_out;
  logic [7:0]  wake_cnt;

  always #10 clk = ~clk;

  wake_latch_ctrl u_wake_latch_ctrl (
    .clk(clk), .rst(rst), .sel(sel), .mon_in(mon_in), .data_raw(data_raw),
    .pwr_en(pwr_en), .latch_en(latch_en), .data_out(data_out), .wake_cnt(wake_cnt)
  );

  int    checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // reference model: delayed input samples and a phase variable
  logic [7:0]  h0, h1, h2;
  int          mst = 0, mcnt = 0, mwake = 0;
  logic [15:0] mhold = 16'h0;

  always @(posedge clk) begin
    if (rst) begin
      h0 <= mon_in; h1 <= mon_in; h2 <= mon_in;
      mst <= 0; mcnt <= 0; mwake <= 0; mhold <= 16'h0;
    end else begin
      automatic bit c = (h1 != h2);
      automatic int ns = mst, nc = mcnt;
      if (mst == 2) begin
        mhold <= data_raw;
        mwake <= mwake + 1;
      end
      if (!sel) begin ns = 0; nc = 0; end
      else if (mst == 0) begin if (c) begin ns = 1; nc = 0; end end
      else if (mst == 1) begin
        if (c) nc = 0;
        else if (mcnt == S - 1) ns = 2;
        else nc = mcnt + 1;
      end else begin ns = c ? 1 : 0; nc = 0; end
      mst <= ns; mcnt <= nc;
      h2 <= h1; h1 <= h0; h0 <= mon_in;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison and run monitors
  int run = 0, maxrun = 0, pwr_seen = 0;
  always @(negedge clk) begin
    cyc++;
    data_raw <= 16'(cyc * 16'h3B5 + 16'h11);
    if (!rst) begin
      chk({cur_req, "/R2 pwr_en"}, pwr_en, (mst != 0));
      chk({cur_req, "/R3 latch_en"}, latch_en, (mst == 2));
      chk({cur_req, "/R4 data_out"}, data_out, mhold);
      chk({cur_req, "/R8 wake_cnt"}, wake_cnt, mwake % 256);
      if (pwr_en) begin run++; pwr_seen++; if (run > maxrun) maxrun = run; end
      else run = 0;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w0;
    ticks(3);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1: reset state and no false wake
    cur_req = "R1";
    chk("R1 pwr_en", pwr_en, 0);
    chk("R1 data_out", data_out, 0);
    chk("R1 wake_cnt", wake_cnt, 0);
    ticks(8);
    chk("R1 no false wake", pwr_seen, 0);

    // R2/R3/R4: single toggle, one full phase
    cur_req = "R3"; maxrun = 0;
    mon_in[3] = ~mon_in[3];
    ticks(14);
    chk("R3 active length", maxrun, S + 1);
    chk("R9 within budget", (maxrun <= B), 1);
    chk("R8 one wake", wake_cnt, 1);

    // R6: steady inputs
    cur_req = "R6"; pwr_seen = 0; w0 = wake_cnt;
    ticks(40);
    chk("R6 standby kept", pwr_seen, 0);
    chk("R6 count unchanged", wake_cnt, w0);

    // R5: second change during settle restarts
    cur_req = "R5"; maxrun = 0;
    mon_in[0] = ~mon_in[0];
    ticks(3);
    mon_in[7] = ~mon_in[7];
    ticks(16);
    chk("R5 extended phase", maxrun, S + 1 + 3);

    // R10: second change detected on the capture-ending edge
    cur_req = "R10"; w0 = wake_cnt; maxrun = 0;
    mon_in[1] = ~mon_in[1];
    ticks(5);
    mon_in[2] = ~mon_in[2];
    ticks(18);
    chk("R10 two captures", wake_cnt, (w0 + 2) % 256);
    chk("R10 continuous power", maxrun, 2 * (S + 1));

    // R7: deselected, changes ignored
    cur_req = "R7"; w0 = wake_cnt; pwr_seen = 0;
    sel = 1'b0;
    for (int i = 0; i < 6; i++) begin mon_in = mon_in + 8'd3; ticks(2); end
    ticks(4);
    sel = 1'b1;
    ticks(10);
    chk("R7 no wake while deselected", pwr_seen, 0);
    chk("R7 count unchanged", wake_cnt, w0);
    // R7: select dropped mid-settle aborts the phase
    mon_in[4] = ~mon_in[4];
    ticks(4);
    sel = 1'b0;
    ticks(10);
    chk("R7 abort no capture", wake_cnt, w0);
    sel = 1'b1;
    ticks(4);

    // R8: wrap of the tally
    cur_req = "R8"; w0 = wake_cnt;
    for (int i = 0; i < 260; i++) begin mon_in[5] = ~mon_in[5]; ticks(9); end
    chk("R8 wrap", wake_cnt, (w0 + 260) % 256);

    // R2: fast toggling every two cycles keeps restarting
    cur_req = "R2"; w0 = wake_cnt;
    for (int i = 0; i < 15; i++) begin mon_in[6] = ~mon_in[6]; ticks(2); end
    ticks(12);
    chk("R2 burst yields one capture", wake_cnt, (w0 + 1) % 256);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule